// File: doc/BRIEF.md
# Chainable Presettable Binary Counter

The block is a synchronous up-counter built from identical slices, each `STAGE_W` bits wide (4 by default). `N_STAGES` slices are chained inside the top module so that together they count as one register of `N_STAGES*STAGE_W` bits. All slices share one rising-edge clock, one active-low asynchronous clear, one active-low synchronous load and one count enable. The second enable of each slice comes from the terminal-count carry of the slice below it. The lowest slice takes its second enable from a port.

A mode decoder inside each slice resolves the controls in a fixed order: clear, then load, then count, then hold. The carry of the top slice leaves the block as a combinational output. Further blocks can use it as the enable of a wider counter.

Top module: `bin_cnt_chain`

## Requirements
- R1: While `rst_ni` is low, `q_o` is all zeros at once, with no clock edge needed, whatever the load, enable and data inputs are.
- R2: With `rst_ni` high and `load_ni` low, a rising clock edge copies `data_i` into `q_o`, whatever the levels of `cnt_en_i` and `chain_en_i`.
- R3: With `rst_ni` and `load_ni` high, a rising clock edge adds one to `q_o` only when both `cnt_en_i` and `chain_en_i` are high.
- R4: With `rst_ni` and `load_ni` high, `q_o` keeps its value across a clock edge when `cnt_en_i` or `chain_en_i` is low.
- R5: `carry_o` equals `chain_en_i` ANDed with every bit of `q_o`. It is combinational, so it follows a change on `chain_en_i` within the same cycle.
- R6: Counting from all ones gives all zeros on the next enabled edge.
- R7: Bit i of `data_i` loads into bit i of `q_o`, so `data_i[0]` lands in the least significant bit.
- R8: Slice k (bits k*STAGE_W upward) advances only on an edge where every lower slice is at all ones. The chain therefore counts as a single `N_STAGES*STAGE_W`-bit binary counter, carrying across slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous clear, active low |
| load_ni | input | 1 | Synchronous parallel load, active low |
| cnt_en_i | input | 1 | Count enable shared by all slices |
| chain_en_i | input | 1 | Count enable of the lowest slice; also gates the carry |
| data_i | input | N_STAGES*STAGE_W | Parallel load value |
| q_o | output | N_STAGES*STAGE_W | Counter state |
| carry_o | output | 1 | Terminal-count carry of the top slice |

## Verification
The bound checker tests these rules on every clock edge: zero state under clear, the load result, the increment with its wrap, hold when an enable is low, and the carry equation. These checks relate only the ports, so they cover the whole chain and not a single slice. Some behaviour is seen only in the bench's directed scenarios: a clear dropped in the middle of a cycle clearing the state before the next edge, the carry falling in the same cycle that `chain_en_i` falls, and a count crossing a slice boundary. A cycle-by-cycle reference model then compares the state and carry under random control sequences.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_LOAD  = 2'd2
  } cnt_mode_e;
endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      load_ni,
  input  logic      cnt_en_i,
  input  logic      chain_en_i,
  output cnt_mode_e mode_o
);
  // load beats count; count needs both enables
  always_comb begin
    if (!load_ni)                    mode_o = MODE_LOAD;
    else if (cnt_en_i && chain_en_i) mode_o = MODE_COUNT;
    else                             mode_o = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int unsigned STAGE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_ni,
  input  logic               cnt_en_i,
  input  logic               chain_en_i,
  input  logic [STAGE_W-1:0] data_i,
  output logic [STAGE_W-1:0] q_o,
  output logic               carry_o
);
  localparam logic [STAGE_W-1:0] ONE = STAGE_W'(1);

  cnt_mode_e    mode;
  logic [STAGE_W-1:0] q_q;

  cnt_mode_dec u_dec (
    .load_ni   (load_ni),
    .cnt_en_i  (cnt_en_i),
    .chain_en_i(chain_en_i),
    .mode_o    (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (mode)
        MODE_LOAD:  q_q <= data_i;
        MODE_COUNT: q_q <= q_q + ONE;
        default:    q_q <= q_q;
      endcase
    end
  end

  assign q_o     = q_q;
  // only the chain enable gates terminal count
  assign carry_o = chain_en_i & (&q_q);
endmodule

// File: rtl/bin_cnt_chain.sv
module bin_cnt_chain #(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned N_STAGES = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_ni,
  input  logic                         cnt_en_i,
  input  logic                         chain_en_i,
  input  logic [N_STAGES*STAGE_W-1:0]  data_i,
  output logic [N_STAGES*STAGE_W-1:0]  q_o,
  output logic                         carry_o
);
  localparam int unsigned TOTAL_W = N_STAGES * STAGE_W;

  logic [N_STAGES:0] chain;
  logic [TOTAL_W-1:0] q_all;

  assign chain[0] = chain_en_i;

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    cnt_stage #(.STAGE_W(STAGE_W)) u_stage (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_ni   (load_ni),
      .cnt_en_i  (cnt_en_i),
      .chain_en_i(chain[k]),
      .data_i    (data_i[k*STAGE_W +: STAGE_W]),
      .q_o       (q_all[k*STAGE_W +: STAGE_W]),
      .carry_o   (chain[k+1])
    );
  end

  assign q_o     = q_all;
  assign carry_o = chain[N_STAGES];
endmodule

// File: rtl/bin_cnt_chain_chk.sv
module bin_cnt_chain_chk #(
  parameter int unsigned TOTAL_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_ni,
  input logic               cnt_en_i,
  input logic               chain_en_i,
  input logic [TOTAL_W-1:0] data_i,
  input logic [TOTAL_W-1:0] q_o,
  input logic               carry_o
);
  localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

  AST_CLEAR_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> q_o == '0);  // R1

  AST_LOAD_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ni |=> q_o == $past(data_i));  // R2

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && chain_en_i) |=> q_o == $past(q_o) + ONE);  // R3

  AST_HOLD_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !(cnt_en_i && chain_en_i)) |=> $stable(q_o));  // R4

  AST_CARRY_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == (chain_en_i && (&q_o)));  // R5

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && cnt_en_i && chain_en_i && (&q_o)) |=> q_o == '0);  // R6
endmodule

bind bin_cnt_chain bin_cnt_chain_chk #(.TOTAL_W(N_STAGES*STAGE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .cnt_en_i  (cnt_en_i),
  .chain_en_i(chain_en_i),
  .data_i    (data_i),
  .q_o       (q_o),
  .carry_o   (carry_o)
);

// File: tb/bin_cnt_chain_bench.sv
module bin_cnt_chain_bench;
  localparam int unsigned STAGE_W  = 4;
  localparam int unsigned N_STAGES = 2;
  localparam int unsigned TW       = N_STAGES * STAGE_W;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          load_ni = 1'b1;
  logic          cnt_en_i = 1'b0;
  logic          chain_en_i = 1'b0;
  logic [TW-1:0] data_i = '0;
  logic [TW-1:0] q_o;
  logic          carry_o;

  int n_chk = 0;
  int n_err = 0;
  logic [TW-1:0] ref_q = '0;

  always #4 clk_i = ~clk_i;

  bin_cnt_chain #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_bin_cnt_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_ni(load_ni), .cnt_en_i(cnt_en_i),
    .chain_en_i(chain_en_i), .data_i(data_i), .q_o(q_o), .carry_o(carry_o)
  );

  task automatic chk(input logic [TW-1:0] act, input logic [TW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference update for one rising edge, inputs held stable
  task automatic edge_step();
    @(posedge clk_i);
    if (!rst_ni)                         ref_q = '0;
    else if (!load_ni)                   ref_q = data_i;
    else if (cnt_en_i && chain_en_i)     ref_q = ref_q + 1'b1;
    @(negedge clk_i);
  endtask

  task automatic drive(input logic ld, input logic ce, input logic te, input logic [TW-1:0] d);
    load_ni = ld; cnt_en_i = ce; chain_en_i = te; data_i = d;
  endtask

  initial begin
    fork
      begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    join_none

    // R1 reset state
    drive(1'b0, 1'b1, 1'b1, 8'hC3);
    @(negedge clk_i); @(negedge clk_i);
    chk(q_o, 8'h00, "R1 clear overrides load");
    rst_ni = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    ref_q = '0;
    edge_step();

    // R2 R7 load with enables low
    drive(1'b0, 1'b0, 1'b0, 8'hA5); edge_step();
    chk(q_o, 8'hA5, "R2 load enables low");
    drive(1'b0, 1'b0, 1'b0, 8'h01); edge_step();
    chk(q_o, 8'h01, "R7 data bit0 to lsb");
    drive(1'b0, 1'b0, 1'b0, 8'h80); edge_step();
    chk(q_o, 8'h80, "R7 data msb to msb");

    // R2 load while both enables high
    drive(1'b0, 1'b1, 1'b1, 8'h33); edge_step();
    chk(q_o, 8'h33, "R2 load beats count");

    // R3 R8 count across slice boundary
    drive(1'b0, 1'b0, 1'b0, 8'h0E); edge_step();
    drive(1'b1, 1'b1, 1'b1, 8'h00); edge_step();
    chk(q_o, 8'h0F, "R3 increment");
    edge_step();
    chk(q_o, 8'h10, "R8 carry into upper slice");

    // R4 hold
    drive(1'b1, 1'b0, 1'b1, 8'h00); edge_step(); edge_step();
    chk(q_o, 8'h10, "R4 hold cnt_en low");
    drive(1'b1, 1'b1, 1'b0, 8'h00); edge_step();
    chk(q_o, 8'h10, "R4 hold chain_en low");

    // R8 upper slice holds while lower not all ones
    drive(1'b0, 1'b0, 1'b0, 8'h1E); edge_step();
    drive(1'b1, 1'b1, 1'b1, 8'h00); edge_step();
    chk(q_o, 8'h1F, "R8 upper slice waits");

    // R5 carry combinational
    drive(1'b0, 1'b0, 1'b0, 8'hFF); edge_step();
    drive(1'b1, 1'b0, 1'b1, 8'h00); #1;
    chk({7'd0, carry_o}, 8'h01, "R5 carry at all ones");
    chain_en_i = 1'b0; #1;
    chk({7'd0, carry_o}, 8'h00, "R5 carry follows chain_en");
    drive(1'b1, 1'b0, 1'b1, 8'h00); edge_step();
    chk({7'd0, carry_o}, 8'h01, "R5 carry held count");

    // R6 wrap
    drive(1'b1, 1'b1, 1'b1, 8'h00); edge_step();
    chk(q_o, 8'h00, "R6 wrap to zero");
    chk({7'd0, carry_o}, 8'h00, "R5 carry low after wrap");

    // R1 mid-cycle clear
    drive(1'b0, 1'b0, 1'b0, 8'h5A); edge_step();
    #2 rst_ni = 1'b0; #1;
    chk(q_o, 8'h00, "R1 async clear mid cycle");
    ref_q = '0;
    drive(1'b0, 1'b1, 1'b1, 8'h77);
    edge_step();
    chk(q_o, 8'h00, "R1 clear holds over edge");
    rst_ni = 1'b1;
    drive(1'b1, 1'b0, 1'b0, 8'h00);
    edge_step();

    // random sequences against the model
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      rst_ni = ($urandom_range(0, 39) != 0);
      if (!rst_ni) ref_q = '0;
      drive(($urandom_range(0, 5) != 0), r[0] | r[1], r[2] | r[3], TW'($urandom));
      if ($urandom_range(0, 3) == 0) data_i = {TW{1'b1}} - TW'($urandom_range(0, 2));
      #1;
      chk({7'd0, carry_o}, {7'd0, chain_en_i & (&ref_q)}, "R5 random carry");
      edge_step();
      chk(q_o, ref_q, "R3 random state");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule